// File: doc/BRIEF.md
# Single-Cycle Fly-By DMA Channel

This block is one DMA channel for a bus clocked by a two-phase clock, where the second phase (PHI2) marks the data half of each bus cycle. Software loads a start address, a transfer count and a control word through a small write port. Once enabled, the channel moves one datum per free bus cycle from an I/O device straight into memory (fly-by). It drives a full 24-bit memory address with no bank multiplexing, so a run of transfers may cross any 64 KiB boundary.

The channel keeps a base and a working copy of both the address and the count. In each granted cycle the address leaves from a separate output register. That register is loaded from the working address when PHI2 rises. The working address then advances when PHI2 falls, and the address outputs go to high impedance. The output register does not change again until the next grant, so the advanced address never reaches the bus early.

When the working count steps past zero, the channel raises a terminal-count flag. It then either disables itself or, with auto-initialise set, reloads both working registers from their base copies and keeps running. PHI2 is sampled in the block's clock domain and its edges are detected there.

Top module: `dma_chan`

## Requirements
- R1: After reset, addr_oe_o, dack_o, busreq_o and tc_o are 0 and addr_o is 0.
- R2: A transfer is granted only at a PHI2 rising edge, and only if the channel is enabled, dreq_i is 1 and free_i is 1. From the clock after that edge, addr_oe_o and dack_o are 1 and addr_o shows the working address.
- R3: addr_oe_o and dack_o drop on the clock after the following PHI2 falling edge. addr_o changes only when a new grant loads it, so the advanced address never appears before the next grant.
- R4: The working address increments by one, modulo 2^ADDR_W, after every transfer. It crosses 16-bit bank boundaries and wraps from all ones to zero.
- R5: The working count decrements once per transfer. A programmed count of N gives exactly N+1 transfers.
- R6: The transfer in which the count passes zero sets tc_o. Without auto-initialise, this also clears the enable, so busreq_o drops and no further grants occur.
- R7: With auto-initialise (control bit 1), terminal count reloads the working address and count from the base copies, and the channel keeps transferring.
- R8: Register writes use reg_sel_i: 0 loads the base and working address, 1 loads the base and working count, 2 writes control (bit 0 enable, bit 1 auto-initialise). A control write clears tc_o.
- R9: While enabled, every write is ignored, except a control write with bit 0 equal to 0, which clears the enable.
- R10: busreq_o equals the enable ANDed with dreq_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, faster than PHI2 |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | ADDR_W | Write data |
| phi2_i | input | 1 | Bus phase-2 clock level |
| free_i | input | 1 | Current bus cycle is free for DMA |
| dreq_i | input | 1 | Device transfer request |
| busreq_o | output | 1 | Channel wants bus cycles |
| dack_o | output | 1 | Device acknowledge for fly-by transfer |
| addr_o | output | ADDR_W | Memory address output register |
| addr_oe_o | output | 1 | Address output enable |
| tc_o | output | 1 | Terminal count reached |

## Verification
The bench builds the channel with CNT_W = 4 and the default 24-bit address. With a 4-bit count, every programmed count from 0 to 15 can be run to terminal count in turn. Start addresses are placed just below bank boundaries and at the top of the address space, so both the bank crossing and the full wrap are exercised. The bench varies the free-cycle pattern to check grant gating. It also runs auto-initialise reloads and writes issued during an active run.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_CNT  = 2'd1,
    SEL_CTRL = 2'd2
  } reg_sel_e;

  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_AUTO_BIT = 1;
endpackage

// File: rtl/dma_phase_det.sv
module dma_phase_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic phi2_i,
  output logic rise_o,
  output logic fall_o
);
  logic phi2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phi2_q <= 1'b0;
    else         phi2_q <= phi2_i;
  end

  assign rise_o = phi2_i & ~phi2_q;
  assign fall_o = ~phi2_i & phi2_q;
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              en_o,
  output logic              tc_o
);
  logic [ADDR_W-1:0] base_addr_q, cur_addr_q;
  logic [CNT_W-1:0]  base_cnt_q, cur_cnt_q;
  logic              en_q, auto_q, tc_q;
  logic              at_end;

  assign at_end = (cur_cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_addr_q <= '0;
      cur_addr_q  <= '0;
      base_cnt_q  <= '0;
      cur_cnt_q   <= '0;
      en_q        <= 1'b0;
      auto_q      <= 1'b0;
      tc_q        <= 1'b0;
    end else if (step_i) begin
      if (at_end) begin
        tc_q <= 1'b1;
        if (auto_q) begin
          cur_addr_q <= base_addr_q;
          cur_cnt_q  <= base_cnt_q;
        end else begin
          cur_addr_q <= cur_addr_q + 1'b1;
          cur_cnt_q  <= cur_cnt_q - 1'b1;
          en_q       <= 1'b0;
        end
      end else begin
        cur_addr_q <= cur_addr_q + 1'b1;
        cur_cnt_q  <= cur_cnt_q - 1'b1;
      end
    end else if (we_i) begin
      if (en_q) begin
        // only a disable gets through while active
        if (sel_i == SEL_CTRL && !wdata_i[CTRL_EN_BIT]) en_q <= 1'b0;
      end else begin
        unique case (sel_i)
          SEL_ADDR: begin
            base_addr_q <= wdata_i;
            cur_addr_q  <= wdata_i;
          end
          SEL_CNT: begin
            base_cnt_q <= wdata_i[CNT_W-1:0];
            cur_cnt_q  <= wdata_i[CNT_W-1:0];
          end
          SEL_CTRL: begin
            en_q   <= wdata_i[CTRL_EN_BIT];
            auto_q <= wdata_i[CTRL_AUTO_BIT];
            tc_q   <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign cur_addr_o = cur_addr_q;
  assign en_o       = en_q;
  assign tc_o       = tc_q;
endmodule

// File: rtl/dma_bus_drv.sv
module dma_bus_drv #(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              grant_i,
  input  logic              fall_i,
  input  logic [ADDR_W-1:0] cur_addr_i,
  output logic              xfer_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic              xfer_q;
  logic [ADDR_W-1:0] out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xfer_q <= 1'b0;
      out_q  <= '0;
    end else if (grant_i) begin
      xfer_q <= 1'b1;
      out_q  <= cur_addr_i;
    end else if (fall_i) begin
      xfer_q <= 1'b0;
    end
  end

  assign xfer_o = xfer_q;
  assign addr_o = out_q;
endmodule

// File: rtl/dma_chan.sv
module dma_chan #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  input  logic              phi2_i,
  input  logic              free_i,
  input  logic              dreq_i,
  output logic              busreq_o,
  output logic              dack_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_oe_o,
  output logic              tc_o
);
  logic              rise, fall, en, xfer, grant;
  logic [ADDR_W-1:0] cur_addr;

  dma_phase_det u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phi2_i (phi2_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  dma_chan_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .sel_i      (reg_sel_i),
    .wdata_i    (reg_wdata_i),
    .step_i     (fall & xfer),
    .cur_addr_o (cur_addr),
    .en_o       (en),
    .tc_o       (tc_o)
  );

  assign grant = rise & en & dreq_i & free_i & ~xfer;

  dma_bus_drv #(.ADDR_W(ADDR_W)) u_bus (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .grant_i    (grant),
    .fall_i     (fall),
    .cur_addr_i (cur_addr),
    .xfer_o     (xfer),
    .addr_o     (addr_o)
  );

  assign addr_oe_o = xfer;
  assign dack_o    = xfer;
  assign busreq_o  = en & dreq_i;
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int unsigned ADDR_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              phi2_i,
  input logic              addr_oe_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              tc_o
);
  // R2: drive starts only after PHI2 was seen high
  assert_oe_on_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(addr_oe_o) |-> $past(phi2_i));

  // R3: release only after PHI2 was seen low
  assert_release_on_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(addr_oe_o) |-> !$past(phi2_i));

  // R3: bus address never changes outside a granted cycle
  assert_addr_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(addr_o) |-> addr_oe_o);

  // R6: terminal count is raised only by a transfer
  assert_tc_from_xfer_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tc_o) |-> $past(addr_oe_o));
endmodule

bind dma_chan dma_chan_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .phi2_i    (phi2_i),
  .addr_oe_o (addr_oe_o),
  .addr_o    (addr_o),
  .tc_o      (tc_o)
);

// File: tb/dma_chan_bench.sv
module dma_chan_bench;
  localparam int unsigned AW = 24;
  localparam int unsigned CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [1:0]    sel = '0;
  logic [AW-1:0] wdata = '0;
  logic          phi2 = 1'b0, free = 1'b0, dreq = 1'b0;
  logic          busreq, dack, oe, tc;
  logic [AW-1:0] addr;

  int n_chk = 0, n_bad = 0;

  // model
  logic [AW-1:0] m_base, m_cur, m_last;
  logic [CW-1:0] m_bcnt, m_cnt;
  logic          m_en, m_auto, m_tc;

  always #4 clk = ~clk;

  dma_chan #(.ADDR_W(AW), .CNT_W(CW)) u_dma_chan (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .phi2_i(phi2), .free_i(free), .dreq_i(dreq),
    .busreq_o(busreq), .dack_o(dack), .addr_o(addr), .addr_oe_o(oe), .tc_o(tc)
  );

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [AW-1:0] d);
    @(negedge clk);
    we = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    we = 1'b0;
    if (m_en) begin
      if (s == 2'd2 && !d[0]) m_en = 1'b0;
    end else begin
      case (s)
        2'd0: begin m_base = d; m_cur = d; end
        2'd1: begin m_bcnt = d[CW-1:0]; m_cnt = d[CW-1:0]; end
        2'd2: begin m_en = d[0]; m_auto = d[1]; m_tc = 1'b0; end
        default: ;
      endcase
    end
  endtask

  // one PHI2 period: 2 clocks high, 2 clocks low
  task automatic bus_cycle(input logic f, input logic d);
    logic go;
    @(negedge clk);
    phi2 = 1'b1; free = f; dreq = d;
    go = m_en & d & f;
    @(negedge clk);
    check("R10 busreq", {{(AW-1){1'b0}}, busreq}, {{(AW-1){1'b0}}, m_en & d});
    check("R2 oe", {{(AW-1){1'b0}}, oe}, {{(AW-1){1'b0}}, go});
    check("R2 dack", {{(AW-1){1'b0}}, dack}, {{(AW-1){1'b0}}, go});
    if (go) m_last = m_cur;
    check("R3/R4 addr", addr, m_last);
    @(negedge clk);
    phi2 = 1'b0;
    @(negedge clk);
    if (go) begin
      if (m_cnt == '0) begin
        m_tc = 1'b1;
        if (m_auto) begin m_cur = m_base; m_cnt = m_bcnt; end
        else begin m_cur = m_cur + 1'b1; m_cnt = m_cnt - 1'b1; m_en = 1'b0; end
      end else begin
        m_cur = m_cur + 1'b1; m_cnt = m_cnt - 1'b1;
      end
    end
    check("R3 release", {{(AW-1){1'b0}}, oe}, '0);
    check("R3 addr held", addr, m_last);
    check("R5/R6 tc", {{(AW-1){1'b0}}, tc}, {{(AW-1){1'b0}}, m_tc});
    @(negedge clk);
  endtask

  initial begin
    m_base = '0; m_cur = '0; m_last = '0; m_bcnt = '0; m_cnt = '0;
    m_en = 1'b0; m_auto = 1'b0; m_tc = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 oe", {{(AW-1){1'b0}}, oe}, '0);
    check("R1 dack", {{(AW-1){1'b0}}, dack}, '0);
    check("R1 busreq", {{(AW-1){1'b0}}, busreq}, '0);
    check("R1 tc", {{(AW-1){1'b0}}, tc}, '0);
    check("R1 addr", addr, '0);

    // R5 R6: every count, no auto-init, varied free patterns, bank crossings
    for (int n = 0; n < (1 << CW); n++) begin
      wr(2'd0, 24'h00FFF8 + AW'(n) * 24'h010000);
      wr(2'd1, AW'(n));
      wr(2'd2, 24'h1);
      for (int i = 0; i < 3 * (n + 2); i++) bus_cycle((i % 3) != n % 3, 1'b1);
      check("R5 transfers done", {{(AW-1){1'b0}}, m_en}, '0);
      check("R6 busreq off", {{(AW-1){1'b0}}, busreq}, '0);
    end

    // R4: wrap at top of address space
    wr(2'd0, 24'hFFFFFE);
    wr(2'd1, 24'd3);
    wr(2'd2, 24'h1);
    for (int i = 0; i < 5; i++) bus_cycle(1'b1, 1'b1);

    // R2: dreq low gives no grant
    wr(2'd0, 24'h123456);
    wr(2'd1, 24'd2);
    wr(2'd2, 24'h1);
    for (int i = 0; i < 3; i++) bus_cycle(1'b1, 1'b0);

    // R9: writes ignored while active
    bus_cycle(1'b1, 1'b1);
    wr(2'd0, 24'hABCDEF);
    wr(2'd1, 24'd9);
    wr(2'd2, 24'h3);
    bus_cycle(1'b1, 1'b1);
    check("R9 addr write ignored", m_last, 24'h123457);
    wr(2'd2, 24'h0);
    bus_cycle(1'b1, 1'b1);
    check("R9 disable taken", {{(AW-1){1'b0}}, busreq}, '0);

    // R7 R8: auto-initialise reloads and keeps running
    wr(2'd0, 24'h7FFFFF);
    wr(2'd1, 24'd2);
    wr(2'd2, 24'h3);
    check("R8 tc cleared", {{(AW-1){1'b0}}, tc}, '0);
    for (int i = 0; i < 10; i++) bus_cycle(1'b1, 1'b1);
    check("R7 still enabled", {{(AW-1){1'b0}}, busreq}, {{(AW-1){1'b0}}, 1'b1});
    check("R7 reload address", m_cur, 24'h800000);
    wr(2'd2, 24'h0);
    bus_cycle(1'b1, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule